// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Engine

This block turns an angle and a magnitude into the pair m·cos(θ) and m·sin(θ). It uses circular rotation-mode CORDIC and performs one micro-rotation per clock. A one-cycle start pulse latches a q1.31 angle and a q1.31 modulus. The angle is expressed in units of π, so the full signed range [-1, 1) covers [-π, π).

Before the first iteration, the engine folds the angle into ±π/2 and adjusts the sign of the modulus to match. It also multiplies the modulus by the CORDIC gain constant for the chosen iteration count, so the outputs need no later scaling. A 4-bit precision value sets the number of micro-rotations to four times its value. A 4-bit function code selects which result appears on the primary output and which on the secondary output. Both results saturate to the q1.31 limits, and a one-cycle done pulse marks the point where they become valid.

The engine is meant to sit behind a register interface block. That block supplies the function code, the precision and the operand-width choice, and it collects the results when done is asserted.

Top module: `cordic_sincos_engine`

## Requirements
- R1: While reset is held and after it is released, before any start, done_o is 0 and prim_o and sec_o are both 0.
- R2: Function code 0 selects cosine. With a = angle/2^31 and m = modulus/2^31, prim_o/2^31 equals m·cos(π·a) and sec_o/2^31 equals m·sin(π·a). Each must lie within 1.5·2^-(n-1) + 2^-24 of the exact value.
- R3: Function code 1 selects sine. prim_o carries m·sin(π·a) and sec_o carries m·cos(π·a), with the same tolerance as R2.
- R4: The iteration count n is 4·P for a precision value P from 1 to 15, and P = 0 is treated as P = 1. For a supported function, done_o is high in the cycle that begins n rising edges after the edge that samples start_i.
- R5: done_o is high for exactly one cycle per completed operation.
- R6: For function codes 2 to 15, done_o is high in the cycle right after the edge that samples start_i, and both prim_o and sec_o are 0.
- R7: Angles anywhere in [-1, 1) meet the R2/R3 accuracy. This includes angles whose magnitude exceeds 0.5, and the most negative code 0x80000000, which means -π.
- R8: Results clamp to the range 0x80000000 to 0x7FFFFFFF and never wrap. For example, modulus -1 at angle -π gives 0x7FFFFFFF, and modulus -1 at angle 0 gives a value near 0x80000000.
- R9: When short_i is 1, the angle is angle_i[15:0]·2^16 and the modulus is modulus_i[15:0]·2^16, both q1.15 values. The upper halves of both inputs are ignored.
- R10: start_i is ignored while an operation is running and in the cycle where done_o is high. prim_o and sec_o change only in a cycle where done_o rises, and they hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| func_i | input | 4 | Function code: 0 cosine, 1 sine, others unsupported |
| prec_i | input | 4 | Precision P; the iteration count is 4·P |
| short_i | input | 1 | Operands are q1.15 in the low halves of the inputs |
| angle_i | input | 32 | Angle in units of π, q1.31 |
| modulus_i | input | 32 | Modulus, q1.31 |
| done_o | output | 1 | One-cycle completion pulse |
| prim_o | output | 32 | Primary result, q1.31 |
| sec_o | output | 32 | Secondary result, q1.31 |

## Verification
The bench builds the block with its default parameters: 32-bit data, 4 guard bits and a 4-bit precision field, which allows up to 60 iterations.

At these settings a near-exhaustive sweep is cheap. It covers both supported functions, a spread of precision values that includes 0 and 15, and sixteen angles spaced evenly around the whole circle. Each combination runs at three moduli. The sweep compares every result against real-valued cosine and sine, using a tolerance that shrinks as n grows.

Every unsupported function code is tried at the lowest, a middle and the highest precision. Directed runs add:
- saturation at the ±1 corners,
- q1.15 operands with junk in their upper halves,
- start pulses arriving mid-operation and in the done cycle.

// File: rtl/cordic_sc_pkg.sv
`timescale 1ns/1ps
package cordic_sc_pkg;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_ROT  = 1'b1
  } cs_state_e;

  localparam real PI_R = 3.14159265358979323846;

  function automatic real pow2_real(input int k);
    real r = 1.0;
    if (k >= 0) begin
      for (int j = 0; j < k; j++) r = r * 2.0;
    end else begin
      for (int j = 0; j < -k; j++) r = r / 2.0;
    end
    return r;
  endfunction

  // arctangent of 2^-i in radians; power series for i >= 1
  function automatic real atan_real(input int i);
    real x, term, acc;
    if (i == 0) return PI_R / 4.0;
    x    = pow2_real(-i);
    term = x;
    acc  = 0.0;
    for (int k = 0; k < 24; k++) begin
      if ((k % 2) == 0) acc = acc + term / real'(2 * k + 1);
      else              acc = acc - term / real'(2 * k + 1);
      term = term * x * x;
    end
    return acc;
  endfunction

  // angle step in units of pi, scaled by 2^frac
  function automatic longint atan_code(input int i, input int frac);
    return longint'(atan_real(i) / PI_R * pow2_real(frac));
  endfunction

  // inverse gain of iters micro-rotations, scaled by 2^frac
  function automatic longint gain_code(input int iters, input int frac);
    real p = 1.0;
    real q = 1.0;
    real g = 1.0;
    for (int i = 0; i < iters; i++) begin
      p = p / (1.0 + q);
      q = q / 4.0;
    end
    for (int k = 0; k < 40; k++) g = 0.5 * (g + p / g);
    return longint'(g * pow2_real(frac));
  endfunction

endpackage

// File: rtl/cordic_sc_prep.sv
`timescale 1ns/1ps
module cordic_sc_prep #(
  parameter int DW     = 32,
  parameter int GW     = 4,
  parameter int PREC_W = 4,
  parameter int XW     = DW + GW + 2,
  parameter int ZW     = DW + GW + 1,
  parameter int KW     = DW
) (
  input  logic                 short_i,
  input  logic [DW-1:0]        angle_i,
  input  logic [DW-1:0]        modulus_i,
  input  logic [PREC_W-1:0]    prec_i,
  output logic signed [XW-1:0] x0_o,
  output logic signed [ZW-1:0] z0_o
);
  localparam int HALF   = DW / 2;
  localparam int GAIN_D = 1 << PREC_W;
  localparam int PW     = DW + KW + 2;

  logic [KW-1:0] gain_rom [GAIN_D];

  for (genvar g = 0; g < GAIN_D; g++) begin : g_gain
    localparam int     ITS = 4 * ((g == 0) ? 1 : g);
    localparam longint KC  = cordic_sc_pkg::gain_code(ITS, KW);
    assign gain_rom[g] = KW'(KC);
  end

  logic [DW-1:0]        ang_w, mod_w, ang_f;
  logic                 fold;
  logic signed [DW:0]   mod_s, mod_f;
  logic signed [PW-1:0] prod;

  always_comb begin
    ang_w = short_i ? {angle_i[HALF-1:0], {HALF{1'b0}}} : angle_i;
    mod_w = short_i ? {modulus_i[HALF-1:0], {HALF{1'b0}}} : modulus_i;
    // outside +-0.5 pi-units: shift by pi, flip the modulus sign
    fold  = ang_w[DW-1] ^ ang_w[DW-2];
    ang_f = {ang_w[DW-1] ^ fold, ang_w[DW-2:0]};
    mod_s = $signed({mod_w[DW-1], mod_w});
    mod_f = fold ? -mod_s : mod_s;
    prod  = PW'(mod_f) * PW'($signed({1'b0, gain_rom[prec_i]}));
    x0_o  = prod[KW-GW +: XW];
    z0_o  = {ang_f[DW-1], ang_f, {GW{1'b0}}};
  end

endmodule

// File: rtl/cordic_sc_rotator.sv
`timescale 1ns/1ps
module cordic_sc_rotator #(
  parameter int XW   = 38,
  parameter int ZW   = 37,
  parameter int IT_W = 6,
  parameter int FRAC = 35
) (
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  logic [IT_W-1:0]      idx_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  localparam int ROM_D = 1 << IT_W;

  logic signed [ZW-1:0] atan_rom [ROM_D];

  for (genvar g = 0; g < ROM_D; g++) begin : g_atan
    localparam longint CODE = cordic_sc_pkg::atan_code(g, FRAC);
    assign atan_rom[g] = ZW'(CODE);
  end

  logic                 rot_pos;
  logic signed [XW-1:0] x_sh, y_sh;
  logic signed [ZW-1:0] ang_step;

  always_comb begin
    rot_pos  = ~z_i[ZW-1];
    x_sh     = x_i >>> idx_i;
    y_sh     = y_i >>> idx_i;
    ang_step = atan_rom[idx_i];
    if (rot_pos) begin
      x_o = x_i - y_sh;
      y_o = y_i + x_sh;
      z_o = z_i - ang_step;
    end else begin
      x_o = x_i + y_sh;
      y_o = y_i - x_sh;
      z_o = z_i + ang_step;
    end
  end

endmodule

// File: rtl/cordic_sc_ctrl.sv
`timescale 1ns/1ps
module cordic_sc_ctrl #(
  parameter int FUNC_W = 4,
  parameter int PREC_W = 4,
  parameter int IT_W   = PREC_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [PREC_W-1:0] prec_i,
  output logic              load_o,
  output logic              zero_o,
  output logic              step_o,
  output logic              last_o,
  output logic              swap_o,
  output logic              done_o,
  output logic [IT_W-1:0]   idx_o
);
  import cordic_sc_pkg::*;

  cs_state_e           state_q, state_d;
  logic [IT_W-1:0]     it_q, it_d, last_q, last_d, n_last;
  logic [PREC_W-1:0]   pm1;
  logic                swap_q, swap_d, done_q, done_d;
  logic                accept, fn_ok;

  always_comb begin
    accept = (state_q == CS_IDLE) && !done_q && start_i;
    fn_ok  = (func_i == FUNC_W'(0)) || (func_i == FUNC_W'(1));
    pm1    = (prec_i == '0) ? '0 : prec_i - 1'b1;
    n_last = {pm1, 2'b11};
    load_o = accept && fn_ok;
    zero_o = accept && !fn_ok;
    step_o = (state_q == CS_ROT);
    last_o = step_o && (it_q == last_q);

    state_d = state_q;
    it_d    = it_q;
    last_d  = last_q;
    swap_d  = swap_q;
    done_d  = 1'b0;
    case (state_q)
      CS_IDLE: begin
        if (load_o) begin
          state_d = CS_ROT;
          it_d    = '0;
          last_d  = n_last;
          swap_d  = func_i[0];
        end else if (zero_o) begin
          done_d = 1'b1;
        end
      end
      CS_ROT: begin
        if (last_o) begin
          state_d = CS_IDLE;
          done_d  = 1'b1;
        end else begin
          it_d = it_q + 1'b1;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CS_IDLE;
      it_q    <= '0;
      last_q  <= '0;
      swap_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      it_q    <= it_d;
      last_q  <= last_d;
      swap_q  <= swap_d;
      done_q  <= done_d;
    end
  end

  assign swap_o = swap_q;
  assign done_o = done_q;
  assign idx_o  = it_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_q |=> !done_q); // R5
  AST_BAD_FUNC_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni) zero_o |=> done_q); // R6
  AST_ITER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) step_o |-> (it_q <= last_q)); // R4
  AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni) (step_o && !last_o) |=> step_o); // R10

endmodule

// File: rtl/cordic_sincos_engine.sv
`timescale 1ns/1ps
module cordic_sincos_engine #(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 4,
  parameter int PREC_W  = 4,
  parameter int FUNC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [PREC_W-1:0] prec_i,
  input  logic              short_i,
  input  logic [DATA_W-1:0] angle_i,
  input  logic [DATA_W-1:0] modulus_i,
  output logic              done_o,
  output logic [DATA_W-1:0] prim_o,
  output logic [DATA_W-1:0] sec_o
);
  localparam int IT_W = PREC_W + 2;
  localparam int XW   = DATA_W + GUARD_W + 2;
  localparam int ZW   = DATA_W + GUARD_W + 1;
  localparam int FRAC = DATA_W - 1 + GUARD_W;
  localparam int KW   = DATA_W;
  localparam int TW   = XW - GUARD_W;

  logic                 load, zero, step, last, swap;
  logic [IT_W-1:0]      idx;
  logic signed [XW-1:0] x0, x_q, x_d, y_q, y_d, x_n, y_n;
  logic signed [ZW-1:0] z0, z_q, z_d, z_n;
  logic [DATA_W-1:0]    prim_q, prim_d, sec_q, sec_d, cos_r, sin_r;

  cordic_sc_ctrl #(.FUNC_W(FUNC_W), .PREC_W(PREC_W), .IT_W(IT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .func_i(func_i),
    .prec_i(prec_i), .load_o(load), .zero_o(zero), .step_o(step),
    .last_o(last), .swap_o(swap), .done_o(done_o), .idx_o(idx)
  );

  cordic_sc_prep #(.DW(DATA_W), .GW(GUARD_W), .PREC_W(PREC_W), .XW(XW), .ZW(ZW), .KW(KW)) u_prep (
    .short_i(short_i), .angle_i(angle_i), .modulus_i(modulus_i),
    .prec_i(prec_i), .x0_o(x0), .z0_o(z0)
  );

  cordic_sc_rotator #(.XW(XW), .ZW(ZW), .IT_W(IT_W), .FRAC(FRAC)) u_rot (
    .x_i(x_q), .y_i(y_q), .z_i(z_q), .idx_i(idx),
    .x_o(x_n), .y_o(y_n), .z_o(z_n)
  );

  function automatic logic [DATA_W-1:0] sat_q(input logic signed [XW-1:0] v);
    logic [TW-1:0] t;
    t = v[XW-1:GUARD_W];
    if ((t[TW-1:DATA_W-1] == '0) || (t[TW-1:DATA_W-1] == '1)) return t[DATA_W-1:0];
    else if (t[TW-1]) return {1'b1, {(DATA_W-1){1'b0}}};
    else              return {1'b0, {(DATA_W-1){1'b1}}};
  endfunction

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    z_d    = z_q;
    prim_d = prim_q;
    sec_d  = sec_q;
    cos_r  = sat_q(x_n);
    sin_r  = sat_q(y_n);
    if (load) begin
      x_d = x0;
      y_d = '0;
      z_d = z0;
    end else if (step) begin
      x_d = x_n;
      y_d = y_n;
      z_d = z_n;
    end
    if (zero) begin
      prim_d = '0;
      sec_d  = '0;
    end else if (last) begin
      prim_d = swap ? sin_r : cos_r;
      sec_d  = swap ? cos_r : sin_r;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      prim_q <= '0;
      sec_q  <= '0;
    end else begin
      x_q    <= x_d;
      y_q    <= y_d;
      z_q    <= z_d;
      prim_q <= prim_d;
      sec_q  <= sec_d;
    end
  end

  assign prim_o = prim_q;
  assign sec_o  = sec_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) step |-> ((x_q[XW-1] == x_q[XW-2]) && (y_q[XW-1] == y_q[XW-2]))); // R8
  AST_HOLD_RESULTS: assert property (@(posedge clk_i) disable iff (!rst_ni) (!$stable(prim_o) || !$stable(sec_o)) |-> done_o); // R10

endmodule

// File: tb/cordic_sincos_engine_bench.sv
`timescale 1ns/1ps
module cordic_sincos_engine_bench;
  localparam real PI_B = 3.14159265358979323846;
  localparam real FS   = 2147483648.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        short_s = 1'b0;
  logic [3:0]  func = '0;
  logic [3:0]  prec = '0;
  logic [31:0] ang = '0;
  logic [31:0] modv = '0;
  logic        done;
  logic [31:0] prim, sec;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  cordic_sincos_engine u_cordic_sincos_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .func_i(func), .prec_i(prec),
    .short_i(short_s), .angle_i(ang), .modulus_i(modv),
    .done_o(done), .prim_o(prim), .sec_o(sec)
  );

  function automatic real q31(input logic [31:0] v);
    return $itor($signed(v)) / FS;
  endfunction

  function automatic real clampq(input real v);
    if (v > (FS - 1.0) / FS) return (FS - 1.0) / FS;
    if (v < -1.0) return -1.0;
    return v;
  endfunction

  task automatic note(input bit ok, input string req, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0.10f expected=%0.10f", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] f, input logic [3:0] p, input bit sh,
                        input logic [31:0] a, input logic [31:0] m, input bit poke,
                        input string req);
    int n, lat, exp_lat;
    real ar, mr, ec, es, ep, esec, tol;
    logic [31:0] p1, s1;
    string lreq;
    n       = 4 * ((p == 0) ? 1 : int'(p));
    exp_lat = (f < 2) ? n : 0;
    lreq    = (f < 2) ? "R4" : "R6";
    ar = sh ? $itor($signed(a[15:0])) / 32768.0 : q31(a);
    mr = sh ? $itor($signed(m[15:0])) / 32768.0 : q31(m);
    ec = clampq(mr * $cos(ar * PI_B));
    es = clampq(mr * $sin(ar * PI_B));
    @(negedge clk);
    func = f; prec = p; short_s = sh; ang = a; modv = m; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      if (poke && lat == 2) begin
        start = 1'b1;
        func  = 4'd3;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    note(lat == exp_lat, lreq, "latency", $itor(lat), $itor(exp_lat));
    if (f < 2) begin
      tol  = 1.5 * (2.0 ** (-(n - 1))) + 2.0 ** (-24);
      ep   = (f == 0) ? ec : es;
      esec = (f == 0) ? es : ec;
      note(((q31(prim) - ep) <= tol) && ((ep - q31(prim)) <= tol), req, "primary", q31(prim), ep);
      note(((q31(sec) - esec) <= tol) && ((esec - q31(sec)) <= tol), req, "secondary", q31(sec), esec);
    end else begin
      note(prim == '0, "R6", "primary zero", q31(prim), 0.0);
      note(sec == '0, "R6", "secondary zero", q31(sec), 0.0);
    end
    p1 = prim;
    s1 = sec;
    if (poke) begin
      start = 1'b1;
      func  = 4'd9;
    end
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    note(!done, poke ? "R10" : "R5", "done after pulse", $itor(done), 0.0);
    if (poke) begin
      note(prim == p1, "R10", "primary held", q31(prim), q31(p1));
      note(sec == s1, "R10", "secondary held", q31(sec), q31(s1));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int plist [7] = '{0, 1, 2, 3, 5, 8, 15};
    logic [31:0] mlist [3] = '{32'h7FFFFFFF, 32'h40000000, 32'hC0000000};
    string req;
    repeat (3) @(posedge clk);
    @(negedge clk);
    note(!done, "R1", "done in reset", $itor(done), 0.0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    note(!done, "R1", "done after reset", $itor(done), 0.0);
    note(prim == '0, "R1", "primary after reset", q31(prim), 0.0);
    note(sec == '0, "R1", "secondary after reset", q31(sec), 0.0);

    // sweep: both functions, several precisions, full circle of angles
    for (int f = 0; f < 2; f++) begin
      for (int pi = 0; pi < 7; pi++) begin
        for (int k = 0; k < 16; k++) begin
          for (int mi = 0; mi < 3; mi++) begin
            if (k >= 4 && k <= 11) req = (f == 0) ? "R2/R7" : "R3/R7";
            else                   req = (f == 0) ? "R2" : "R3";
            run_op(4'(f), 4'(plist[pi]), 1'b0, 32'(k) << 28, mlist[mi],
                   (k == 3) && (mi == 0), req);
          end
        end
      end
    end

    // unsupported codes
    for (int f = 2; f < 16; f++) begin
      run_op(4'd0, 4'd5, 1'b0, 32'h10000000, 32'h60000000, 1'b0, "R2");
      run_op(4'(f), 4'd0, 1'b0, 32'h10000000, 32'h60000000, 1'b0, "R6");
      run_op(4'(f), 4'd7, 1'b0, 32'h20000000, 32'h60000000, 1'b0, "R6");
      run_op(4'(f), 4'd15, 1'b0, 32'h30000000, 32'h60000000, 1'b0, "R6");
    end

    // saturation corners
    run_op(4'd0, 4'd15, 1'b0, 32'h80000000, 32'h80000000, 1'b0, "R8");
    run_op(4'd0, 4'd15, 1'b0, 32'h00000000, 32'h80000000, 1'b0, "R8");
    run_op(4'd1, 4'd15, 1'b0, 32'h40000000, 32'h80000000, 1'b0, "R8");
    run_op(4'd1, 4'd15, 1'b0, 32'hC0000000, 32'h80000000, 1'b0, "R8");

    // q1.15 operands, junk in upper halves
    for (int k = 0; k < 16; k++) begin
      run_op(4'(k % 2), 4'd10, 1'b1, {16'hA5A5 ^ 16'(k), 16'(k) << 12},
             {16'h5A5A, 16'h6000}, 1'b0, "R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule